// File: doc/BRIEF.md
# Memory-Card Host Interrupt and DMA Request Router

This block collects the event flags of a memory-card host controller into a 13-bit request register. It turns them into one processor interrupt line and two DMA request lines. Controller logic raises request bits with single-cycle event pulses and lowers them with single-cycle clear pulses. The clock-control path has its own start and stop strobes, which act on the clock-off flag. Software programs a 13-bit mask over a small register bus, and can read back both the mask and the pending requests.

When the controller runs its data FIFOs under DMA, the two FIFO service flags are hidden from the processor interrupt. In that mode they appear only on the receive and transmit DMA request lines, so a DMA engine can service the FIFOs without interrupting the CPU. All three outputs come from registers and follow the request and mask state one cycle late.

Top module: `mmc_irq_router`

## Requirements
- R1: A synchronous active-high reset clears the request register and the mask register. All three outputs are low after reset, and both readback addresses return zero.
- R2: A high `ev_set` bit sets the matching request bit at the next clock edge. The bit stays set, with no further events, until a clear reaches it. Bit map: 0 data done, 1 program done, 2 command end, 3 stop command, 4 clock off, 5 receive FIFO service, 6 transmit FIFO service, 7 timer, 8 data error, 9 response error, 10 read stalled, 11 card interrupt, 12 suspend acknowledge.
- R3: A high `ev_clr` bit clears the matching request bit at the next edge. If a set and a clear hit the same bit in the same cycle, the bit ends up set.
- R4: A bus write to address 0 loads the mask with bits 12:0 of the write data and drops the upper bits. Reading address 0 returns the mask, zero-extended. Reading address 1 returns the request register, zero-extended. A write to address 1 changes neither register.
- R5: `irq` is high when some request bit is set while its effective mask bit is clear. Each set mask bit suppresses the matching request.
- R6: While `dma_en` is high, request bits 5 and 6 are treated as masked for `irq`, whatever the mask register holds.
- R7: While `dma_en` is high, `dma_rx_req` equals request bit 5 and `dma_tx_req` equals request bit 6. While `dma_en` is low, both lines are low.
- R8: `clk_stop` sets request bit 4 and `clk_start` clears it. If both arrive in the same cycle, the bit ends up set.
- R9: Every output is registered. It reflects the request, mask and `dma_en` values present one clock before, so an output change lags the state change by one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_set | input | 13 | Per-bit set pulses for the request register |
| ev_clr | input | 13 | Per-bit clear pulses for the request register |
| clk_start | input | 1 | Clock-start strobe; clears the clock-off request |
| clk_stop | input | 1 | Clock-stop strobe; sets the clock-off request |
| dma_en | input | 1 | DMA mode enable for the FIFO service requests |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 1 | Register address: 0 mask, 1 request readback |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for the current address |
| irq | output | 1 | Processor interrupt request |
| dma_rx_req | output | 1 | Receive-FIFO DMA request |
| dma_tx_req | output | 1 | Transmit-FIFO DMA request |

## Verification
Stimulus covers isolated sets and sustained holds, clears alone, and set and clear together on one bit. These patterns separate sticky storage from pulse following, and separate set priority from clear priority. Mask writes with all-ones data, and writes to the wrong address, show whether the mask truncates its input and whether the request register can be written from the bus. The FIFO service bits are raised with DMA mode both off and on. This shows whether they move from the interrupt to the DMA lines. The one-cycle output lag is visible on every edge, because the reference model is compared each clock.

// File: rtl/mir_pkg.sv
package mir_pkg;
    localparam int NREQ = 13;

    typedef logic [NREQ-1:0] req_vec_t;

    typedef enum int {
        EV_DATA_DONE  = 0,
        EV_PROG_DONE  = 1,
        EV_CMD_END    = 2,
        EV_STOP_CMD   = 3,
        EV_CLK_OFF    = 4,
        EV_RX_SVC     = 5,
        EV_TX_SVC     = 6,
        EV_TIMER      = 7,
        EV_DATA_ERR   = 8,
        EV_RESP_ERR   = 9,
        EV_RD_STALL   = 10,
        EV_CARD_INT   = 11,
        EV_SUSP_ACK   = 12
    } ev_idx_e;

    typedef enum logic {
        RA_MASK = 1'b0,
        RA_REQ  = 1'b1
    } reg_addr_e;

    typedef struct packed {
        logic irq;
        logic dma_rx;
        logic dma_tx;
    } route_out_t;

    function automatic req_vec_t onehot(input ev_idx_e idx);
        req_vec_t v;
        v = '0;
        v[idx] = 1'b1;
        return v;
    endfunction

    function automatic req_vec_t fifo_svc_bits();
        return onehot(EV_RX_SVC) | onehot(EV_TX_SVC);
    endfunction
endpackage

// File: rtl/mir_req_bank.sv
module mir_req_bank
    import mir_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  req_vec_t set_i,
    input  req_vec_t clr_i,
    output req_vec_t req_q
);
    for (genvar i = 0; i < NREQ; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)
                req_q[i] <= 1'b0;
            else if (set_i[i])
                req_q[i] <= 1'b1;
            else if (clr_i[i])
                req_q[i] <= 1'b0;
        end
    end

    p_set_wins_r3: assert property (@(posedge clk) disable iff (rst)
        (|set_i) |=> ((req_q & $past(set_i)) == $past(set_i)));

    p_clear_r3: assert property (@(posedge clk) disable iff (rst)
        (|(clr_i & ~set_i)) |=> ((req_q & $past(clr_i & ~set_i)) == '0));

    p_sticky_r2: assert property (@(posedge clk) disable iff (rst)
        (set_i == '0 && clr_i == '0) |=> $stable(req_q));
endmodule

// File: rtl/mir_mask_reg.sv
module mir_mask_reg
    import mir_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output req_vec_t          mask_q
);
    always_ff @(posedge clk) begin
        if (rst)
            mask_q <= '0;
        else if (wr_i)
            mask_q <= wdata_i[NREQ-1:0];
    end

    p_mask_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !wr_i |=> $stable(mask_q));
endmodule

// File: rtl/mir_route.sv
module mir_route
    import mir_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  req_vec_t   req_i,
    input  req_vec_t   mask_i,
    input  logic       dma_en_i,
    output route_out_t out_q
);
    req_vec_t   eff_mask;
    route_out_t out_d;

    always_comb begin
        eff_mask      = mask_i | (dma_en_i ? fifo_svc_bits() : '0);
        out_d.irq     = |(req_i & ~eff_mask);
        out_d.dma_rx  = dma_en_i & req_i[EV_RX_SVC];
        out_d.dma_tx  = dma_en_i & req_i[EV_TX_SVC];
    end

    always_ff @(posedge clk) begin
        if (rst)
            out_q <= '0;
        else
            out_q <= out_d;
    end

    p_dma_off_r7: assert property (@(posedge clk) disable iff (rst)
        !dma_en_i |=> (!out_q.dma_rx && !out_q.dma_tx));

    p_dma_hide_r6: assert property (@(posedge clk) disable iff (rst)
        (dma_en_i && ((req_i & ~mask_i & ~fifo_svc_bits()) == '0)) |=> !out_q.irq);

    p_irq_raise_r5: assert property (@(posedge clk) disable iff (rst)
        (!dma_en_i && |(req_i & ~mask_i)) |=> out_q.irq);
endmodule

// File: rtl/mmc_irq_router.sv
module mmc_irq_router
    import mir_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [12:0]       ev_set,
    input  logic [12:0]       ev_clr,
    input  logic              clk_start,
    input  logic              clk_stop,
    input  logic              dma_en,
    input  logic              bus_wr,
    input  logic              bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq,
    output logic              dma_rx_req,
    output logic              dma_tx_req
);
    localparam int PAD_W = DATA_W - NREQ;

    req_vec_t   set_all, clr_all, req_q, mask_q;
    route_out_t rout;
    logic       mask_wr;

    assign set_all = ev_set | (clk_stop  ? onehot(EV_CLK_OFF) : '0);
    assign clr_all = ev_clr | (clk_start ? onehot(EV_CLK_OFF) : '0);
    assign mask_wr = bus_wr && (bus_addr == RA_MASK);

    mir_req_bank u_req (
        .clk   (clk),
        .rst   (rst),
        .set_i (set_all),
        .clr_i (clr_all),
        .req_q (req_q)
    );

    mir_mask_reg #(.DATA_W(DATA_W)) u_mask (
        .clk     (clk),
        .rst     (rst),
        .wr_i    (mask_wr),
        .wdata_i (bus_wdata),
        .mask_q  (mask_q)
    );

    mir_route u_route (
        .clk      (clk),
        .rst      (rst),
        .req_i    (req_q),
        .mask_i   (mask_q),
        .dma_en_i (dma_en),
        .out_q    (rout)
    );

    always_comb begin
        if (bus_addr == RA_MASK)
            bus_rdata = {{PAD_W{1'b0}}, mask_q};
        else
            bus_rdata = {{PAD_W{1'b0}}, req_q};
    end

    assign irq        = rout.irq;
    assign dma_rx_req = rout.dma_rx;
    assign dma_tx_req = rout.dma_tx;

    p_clkoff_r8: assert property (@(posedge clk) disable iff (rst)
        clk_stop |=> req_q[EV_CLK_OFF]);

    p_req_bus_r4: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == RA_REQ && ev_set == '0 && ev_clr == '0
         && !clk_start && !clk_stop) |=> $stable(req_q));
endmodule

// File: tb/test_mmc_irq_router.sv
module test_mmc_irq_router;
    logic        clk = 1'b0;
    logic        rst;
    logic [12:0] ev_set, ev_clr;
    logic        clk_start, clk_stop, dma_en, bus_wr, bus_addr;
    logic [31:0] bus_wdata, bus_rdata;
    logic        irq, dma_rx_req, dma_tx_req;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    int m_req  = 0;
    int m_mask = 0;
    int m_irq  = 0;
    int m_rx   = 0;
    int m_tx   = 0;

    always #5 clk = ~clk;

    mmc_irq_router i_mmc_irq_router (
        .clk(clk), .rst(rst), .ev_set(ev_set), .ev_clr(ev_clr),
        .clk_start(clk_start), .clk_stop(clk_stop), .dma_en(dma_en),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq), .dma_rx_req(dma_rx_req),
        .dma_tx_req(dma_tx_req)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic idle();
        ev_set = '0; ev_clr = '0; clk_start = 0; clk_stop = 0;
        bus_wr = 0; bus_wdata = '0;
    endtask

    task automatic step(input string tag);
        int s, c, em;
        @(posedge clk);
        if (rst) begin
            m_req = 0; m_mask = 0; m_irq = 0; m_rx = 0; m_tx = 0;
        end else begin
            em   = m_mask | (dma_en ? 32'h60 : 0);
            m_irq = ((m_req & ~em & 32'h1fff) != 0) ? 1 : 0;
            m_rx  = dma_en ? ((m_req >> 5) & 1) : 0;
            m_tx  = dma_en ? ((m_req >> 6) & 1) : 0;
            s = int'(ev_set) | (clk_stop ? 16 : 0);
            c = int'(ev_clr) | (clk_start ? 16 : 0);
            m_req = (m_req & ~c) | s;
            if (bus_wr && bus_addr == 1'b0) m_mask = bus_wdata & 32'h1fff;
        end
        #1;
        chk(tag, "irq", int'(irq), m_irq);
        chk(tag, "dma_rx_req", int'(dma_rx_req), m_rx);
        chk(tag, "dma_tx_req", int'(dma_tx_req), m_tx);
        chk(tag, "bus_rdata", int'(bus_rdata), bus_addr ? m_req : m_mask);
        idle();
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst = 1; dma_en = 0; bus_addr = 0; idle();
        repeat (3) step("R1");
        rst = 0;
        step("R1");
        bus_addr = 1; step("R1");

        // R2 / R9: set data done and command end, output lags one cycle
        ev_set = 13'h005; step("R9");
        step("R2");
        repeat (3) step("R2");

        // R4 / R5: mask all-ones truncated, masks everything
        bus_addr = 0; bus_wr = 1; bus_wdata = 32'hFFFF_FFFF; step("R4");
        step("R5");
        bus_wr = 1; bus_wdata = 32'h0000_0001; step("R5");
        step("R5");
        // R4: write to request address ignored
        bus_addr = 1; bus_wr = 1; bus_wdata = 32'h0000_1FFF; step("R4");
        bus_addr = 0; step("R4");

        // R3: clear alone, then set+clear same cycle
        bus_addr = 1; ev_clr = 13'h004; step("R3");
        step("R3");
        ev_set = 13'h100; ev_clr = 13'h100; step("R3");
        step("R3");
        ev_clr = 13'h1FFF; step("R3");
        step("R3");

        // R8: clock stop/start and both together
        clk_stop = 1; step("R8");
        step("R8");
        clk_start = 1; step("R8");
        step("R8");
        clk_stop = 1; clk_start = 1; step("R8");
        step("R8");
        clk_start = 1; step("R8");
        step("R8");

        // R6 / R7: FIFO service with DMA off then on
        bus_addr = 0; bus_wr = 1; bus_wdata = 32'h0; step("R5");
        ev_set = 13'h020; step("R7");
        step("R7");
        dma_en = 1; step("R6");
        step("R6");
        ev_set = 13'h040; step("R7");
        step("R7");
        ev_clr = 13'h020; step("R7");
        step("R7");
        ev_set = 13'h800; step("R6");
        step("R6");
        dma_en = 0; step("R7");
        step("R7");
        ev_clr = 13'h1FFF; step("R5");
        step("R5");

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule